// File: doc/BRIEF.md
# Typed Segment Descriptor Register Unit

This block maps a segment-relative offset to a physical address using one of three cached segment descriptors, one each for code, data and stack. Each descriptor holds a base address, a segment length and a three-bit rights mask. The processor reports what kind of reference it is making: an instruction fetch, a data access or a stack access. That reference type picks the descriptor implicitly. An override field can name a descriptor directly instead, for example when an instruction copies code bytes as data.

For every request the unit compares the offset with the selected length and compares the reference kind with the selected rights, both in the same cycle. It then presents either base + offset or a fault code on the cycle after the request. Faulting requests never produce an address.

A load port writes a descriptor. It is used when an intersegment jump or call refreshes the code descriptor, and when a process switch restores all three. A separate read port returns any descriptor so that the context can be saved. Fetching descriptors from a table in memory is left to the surrounding logic.

Top module: `seg_desc_unit`

## Requirements
- R1: After reset all three descriptors read back as zero base, zero length and no rights, `res_valid` is 0, and a translation through a zero-length descriptor reports a bounds fault.
- R2: With `xl_override` = 00, reference type 00 (fetch) selects the code descriptor, 01 selects data, 10 selects stack, and 11 is treated as data.
- R3: A non-zero `xl_override` selects the descriptor by itself, whatever the reference type: 01 code, 10 data, 11 stack.
- R4: An offset equal to or above the selected length gives `res_kind` = 01 (bounds), `res_fault` = 1 and `res_paddr` = 0. An offset of length-1 is accepted.
- R5: An accepted request gives `res_paddr` = base + offset modulo 2^BASE_W on the cycle after the request, with `res_kind` = 00.
- R6: Rights bits are [2] read, [1] write, [0] execute. A fetch needs execute, a non-fetch read needs read, and a non-fetch write needs write. A missing right gives `res_kind` = 10 (rights) and `res_paddr` = 0. A bounds fault takes priority over a rights fault.
- R7: With `ld_en` high, `ld_idx` 01, 10 or 11 writes base, length and rights into the code, data or stack descriptor. `ld_idx` = 00 changes nothing.
- R8: A load and a translation in the same cycle translate with the descriptor contents from before the load. The new contents apply from the next request.
- R9: `rd_idx` 01/10/11 returns the current code/data/stack descriptor on `rd_base`, `rd_size` and `rd_rights` combinationally. `rd_idx` = 00 returns zeros.
- R10: `res_valid` is high exactly on the cycle after a cycle with `xl_valid` high. While it is low, `res_fault` is 0 and `res_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_valid | input | 1 | Translation request |
| xl_type | input | 2 | Reference type: 00 fetch, 01 data, 10 stack, 11 data |
| xl_write | input | 1 | Request is a write (ignored for fetch) |
| xl_override | input | 2 | 00 implicit, 01 code, 10 data, 11 stack |
| xl_offset | input | OFF_W | Offset within segment |
| ld_en | input | 1 | Descriptor write strobe |
| ld_idx | input | 2 | Descriptor to write: 01 code, 10 data, 11 stack |
| ld_base | input | BASE_W | Base to write |
| ld_size | input | OFF_W+1 | Segment length to write |
| ld_rights | input | 3 | Rights to write (R,W,X) |
| rd_idx | input | 2 | Descriptor to read back |
| rd_base | output | BASE_W | Read-back base |
| rd_size | output | OFF_W+1 | Read-back length |
| rd_rights | output | 3 | Read-back rights |
| res_valid | output | 1 | Result present |
| res_paddr | output | BASE_W | Physical address, 0 on fault |
| res_fault | output | 1 | Request aborted |
| res_kind | output | 2 | 00 none, 01 bounds, 10 rights |

## Verification
The bench probes the length edge: length-1 must pass and length must fault. A comparison written as `<=` would let the first byte past the segment through. Overrides are sent whose choice contradicts the reference type, such as a data read steered to an execute-only code segment, so a selector that ignored the override would return a valid address where a rights fault belongs. Offsets past the segment end on a descriptor that also lacks the right must report bounds, which exposes a swapped fault priority. A same-cycle reload of the code descriptor must still translate with the old base, and address sums that overflow BASE_W must wrap.

// File: rtl/seg_pkg.sv
package seg_pkg;

   typedef enum logic [1:0] {
      REF_FETCH = 2'b00,
      REF_DATA  = 2'b01,
      REF_STACK = 2'b10,
      REF_ALT   = 2'b11
   } ref_type_e;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'b00,
      SEL_CODE  = 2'b01,
      SEL_DATA  = 2'b10,
      SEL_STACK = 2'b11
   } sel_e;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'b00,
      FLT_BOUNDS = 2'b01,
      FLT_RIGHTS = 2'b10
   } fault_e;

   localparam int RIGHT_R = 2;
   localparam int RIGHT_W = 1;
   localparam int RIGHT_X = 0;
   localparam int NUM_DESC = 3;

   function automatic logic [2:0] need_mask(input logic [1:0] rtype, input logic wr);
      logic [2:0] m;
      m = '0;
      if (rtype == REF_FETCH) m[RIGHT_X] = 1'b1;
      else if (wr)            m[RIGHT_W] = 1'b1;
      else                    m[RIGHT_R] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/sdr_select.sv
module sdr_select
   import seg_pkg::*;
#(
   parameter int NREG = 3
) (
   input  logic [1:0]      xl_type,
   input  logic [1:0]      xl_override,
   output logic [NREG-1:0] sel_oh
);

   if (NREG != NUM_DESC) begin : g_bad_nreg
      $error("sdr_select: NREG must equal 3");
   end

   logic [NREG-1:0] implicit_oh;
   logic [NREG-1:0] explicit_oh;

   always_comb begin
      implicit_oh = '0;
      case (xl_type)
         REF_FETCH: implicit_oh[0] = 1'b1;
         REF_STACK: implicit_oh[2] = 1'b1;
         default:   implicit_oh[1] = 1'b1;
      endcase
   end

   for (genvar i = 0; i < NREG; i++) begin : g_exp
      assign explicit_oh[i] = (xl_override == 2'(i + 1));
   end

   assign sel_oh = (xl_override == SEL_NONE) ? implicit_oh : explicit_oh;

   // R3: exactly one descriptor chosen whatever the override
   always_comb begin
      a_r3_select_onehot: assert ($onehot(sel_oh) || $isunknown({xl_type, xl_override}));
   end

endmodule

// File: rtl/sdr_file.sv
module sdr_file
   import seg_pkg::*;
#(
   parameter int BASE_W = 24,
   parameter int SIZE_W = 17,
   parameter int NREG   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [1:0]        ld_idx,
   input  logic [BASE_W-1:0] ld_base,
   input  logic [SIZE_W-1:0] ld_size,
   input  logic [2:0]        ld_rights,
   input  logic [1:0]        rd_idx,
   output logic [BASE_W-1:0] rd_base,
   output logic [SIZE_W-1:0] rd_size,
   output logic [2:0]        rd_rights,
   input  logic [NREG-1:0]   xl_sel,
   output logic [BASE_W-1:0] xl_base,
   output logic [SIZE_W-1:0] xl_size,
   output logic [2:0]        xl_rights
);

   if (NREG != NUM_DESC) begin : g_bad_nreg
      $error("sdr_file: NREG must equal 3");
   end
   if (BASE_W < 1 || SIZE_W < 2) begin : g_bad_w
      $error("sdr_file: widths too small");
   end

   logic [BASE_W-1:0] base_q   [NREG];
   logic [SIZE_W-1:0] size_q   [NREG];
   logic [2:0]        rights_q [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic hit;
      assign hit = ld_en && (ld_idx == 2'(i + 1));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[i]   <= '0;
            size_q[i]   <= '0;
            rights_q[i] <= '0;
         end else if (hit) begin
            base_q[i]   <= ld_base;
            size_q[i]   <= ld_size;
            rights_q[i] <= ld_rights;
         end
      end
   end

   // translation read port: one-hot AND-OR mux
   always_comb begin
      xl_base   = '0;
      xl_size   = '0;
      xl_rights = '0;
      for (int i = 0; i < NREG; i++) begin
         xl_base   |= base_q[i]   & {BASE_W{xl_sel[i]}};
         xl_size   |= size_q[i]   & {SIZE_W{xl_sel[i]}};
         xl_rights |= rights_q[i] & {3{xl_sel[i]}};
      end
   end

   // context-save read port
   always_comb begin
      rd_base   = '0;
      rd_size   = '0;
      rd_rights = '0;
      for (int i = 0; i < NREG; i++) begin
         if (rd_idx == 2'(i + 1)) begin
            rd_base   = base_q[i];
            rd_size   = size_q[i];
            rd_rights = rights_q[i];
         end
      end
   end

   // R7: a strobe with the null index leaves every descriptor untouched
   a_r7_null_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_idx == SEL_NONE) |=>
         ($stable(base_q[0]) && $stable(base_q[1]) && $stable(base_q[2]) &&
          $stable(size_q[0]) && $stable(size_q[1]) && $stable(size_q[2]) &&
          $stable(rights_q[0]) && $stable(rights_q[1]) && $stable(rights_q[2])));

   // R7: no strobe, no change
   a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> ($stable(base_q[0]) && $stable(base_q[1]) && $stable(base_q[2])));

endmodule

// File: rtl/sdr_check.sv
module sdr_check
   import seg_pkg::*;
#(
   parameter int BASE_W  = 24,
   parameter int OFF_W   = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xl_valid,
   input  logic [1:0]        xl_type,
   input  logic              xl_write,
   input  logic [OFF_W-1:0]  xl_offset,
   input  logic [BASE_W-1:0] d_base,
   input  logic [OFF_W:0]    d_size,
   input  logic [2:0]        d_rights,
   output logic              res_valid,
   output logic [BASE_W-1:0] res_paddr,
   output logic              res_fault,
   output logic [1:0]        res_kind
);

   localparam int SIZE_W = OFF_W + 1;

   if (BASE_W < OFF_W) begin : g_bad_w
      $error("sdr_check: BASE_W must cover OFF_W");
   end

   logic              in_bounds;
   logic              rights_ok;
   logic [1:0]        kind_c;
   logic [BASE_W-1:0] sum_c;

   assign in_bounds = {1'b0, xl_offset} < d_size;
   assign rights_ok = |(d_rights & need_mask(xl_type, xl_write));
   assign sum_c     = d_base + BASE_W'(xl_offset);

   always_comb begin
      if (!in_bounds)      kind_c = FLT_BOUNDS;
      else if (!rights_ok) kind_c = FLT_RIGHTS;
      else                 kind_c = FLT_NONE;
   end

   if (REG_OUT) begin : g_reg_out
      logic              v_q;
      logic [BASE_W-1:0] pa_q;
      logic [1:0]        k_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q  <= 1'b0;
            pa_q <= '0;
            k_q  <= FLT_NONE;
         end else begin
            v_q  <= xl_valid;
            k_q  <= xl_valid ? kind_c : FLT_NONE;
            pa_q <= (xl_valid && kind_c == FLT_NONE) ? sum_c : '0;
         end
      end
      assign res_valid = v_q;
      assign res_paddr = pa_q;
      assign res_kind  = k_q;

      // R10: result strobe trails the request by one cycle
      a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         xl_valid |=> res_valid);
      a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         !xl_valid |=> (!res_valid && !res_fault && res_paddr == '0));
      // R6: an out-of-range offset reports bounds even if rights also fail
      a_r6_bounds_priority: assert property (@(posedge clk) disable iff (!rst_n)
         (xl_valid && !in_bounds) |=> (res_kind == FLT_BOUNDS));
   end else begin : g_comb_out
      assign res_valid = xl_valid;
      assign res_kind  = xl_valid ? kind_c : FLT_NONE;
      assign res_paddr = (xl_valid && kind_c == FLT_NONE) ? sum_c : '0;
   end

   assign res_fault = (res_kind != FLT_NONE);

   // R4: an aborted request never exposes an address
   a_r4_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
      res_fault |-> (res_paddr == '0 && res_valid));

   // R6: fault code is one of the defined values
   a_r6_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(res_kind));

endmodule

// File: rtl/seg_desc_unit.sv
module seg_desc_unit
   import seg_pkg::*;
#(
   parameter int BASE_W  = 24,
   parameter int OFF_W   = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xl_valid,
   input  logic [1:0]        xl_type,
   input  logic              xl_write,
   input  logic [1:0]        xl_override,
   input  logic [OFF_W-1:0]  xl_offset,
   input  logic              ld_en,
   input  logic [1:0]        ld_idx,
   input  logic [BASE_W-1:0] ld_base,
   input  logic [OFF_W:0]    ld_size,
   input  logic [2:0]        ld_rights,
   input  logic [1:0]        rd_idx,
   output logic [BASE_W-1:0] rd_base,
   output logic [OFF_W:0]    rd_size,
   output logic [2:0]        rd_rights,
   output logic              res_valid,
   output logic [BASE_W-1:0] res_paddr,
   output logic              res_fault,
   output logic [1:0]        res_kind
);

   localparam int SIZE_W = OFF_W + 1;
   localparam int NREG   = NUM_DESC;

   if (OFF_W < 1 || BASE_W < OFF_W) begin : g_bad_params
      $error("seg_desc_unit: need 1 <= OFF_W <= BASE_W");
   end

   logic [NREG-1:0]   sel_oh;
   logic [BASE_W-1:0] s_base;
   logic [SIZE_W-1:0] s_size;
   logic [2:0]        s_rights;

   sdr_select #(.NREG(NREG)) u_sel (
      .xl_type     (xl_type),
      .xl_override (xl_override),
      .sel_oh      (sel_oh)
   );

   sdr_file #(.BASE_W(BASE_W), .SIZE_W(SIZE_W), .NREG(NREG)) u_file (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_en     (ld_en),
      .ld_idx    (ld_idx),
      .ld_base   (ld_base),
      .ld_size   (ld_size),
      .ld_rights (ld_rights),
      .rd_idx    (rd_idx),
      .rd_base   (rd_base),
      .rd_size   (rd_size),
      .rd_rights (rd_rights),
      .xl_sel    (sel_oh),
      .xl_base   (s_base),
      .xl_size   (s_size),
      .xl_rights (s_rights)
   );

   sdr_check #(.BASE_W(BASE_W), .OFF_W(OFF_W), .REG_OUT(REG_OUT)) u_chk (
      .clk       (clk),
      .rst_n     (rst_n),
      .xl_valid  (xl_valid),
      .xl_type   (xl_type),
      .xl_write  (xl_write),
      .xl_offset (xl_offset),
      .d_base    (s_base),
      .d_size    (s_size),
      .d_rights  (s_rights),
      .res_valid (res_valid),
      .res_paddr (res_paddr),
      .res_fault (res_fault),
      .res_kind  (res_kind)
   );

   // R8: a code reload alongside a fetch leaves the fetch on the old base
   a_r8_load_uses_old: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_valid && ld_en && ld_idx == SEL_CODE && xl_type == REF_FETCH &&
       xl_override == SEL_NONE && rd_idx == SEL_CODE && ({1'b0, xl_offset} < rd_size) &&
       rd_rights[RIGHT_X]) |=>
         (res_paddr == $past(rd_base) + BASE_W'($past(xl_offset))));

endmodule

// File: tb/tb_seg_desc_unit.sv
`timescale 1ns/1ps
module tb_seg_desc_unit;

   localparam int BASE_W = 24;
   localparam int OFF_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              xl_valid;
   logic [1:0]        xl_type;
   logic              xl_write;
   logic [1:0]        xl_override;
   logic [OFF_W-1:0]  xl_offset;
   logic              ld_en;
   logic [1:0]        ld_idx;
   logic [BASE_W-1:0] ld_base;
   logic [OFF_W:0]    ld_size;
   logic [2:0]        ld_rights;
   logic [1:0]        rd_idx;
   logic [BASE_W-1:0] rd_base;
   logic [OFF_W:0]    rd_size;
   logic [2:0]        rd_rights;
   logic              res_valid;
   logic [BASE_W-1:0] res_paddr;
   logic              res_fault;
   logic [1:0]        res_kind;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   seg_desc_unit dut (.*);

   // type, write, override, offset, expected kind, expected address
   localparam int NV = 17;
   localparam logic [46:0] VEC [NV] = '{
      {2'd0, 1'b0, 2'd0, 16'h0010, 2'd0, 24'h100010},
      {2'd0, 1'b0, 2'd0, 16'h07FF, 2'd0, 24'h1007FF},
      {2'd0, 1'b0, 2'd0, 16'h0800, 2'd1, 24'h000000},
      {2'd1, 1'b0, 2'd0, 16'h0123, 2'd0, 24'h200123},
      {2'd1, 1'b1, 2'd0, 16'h0FFF, 2'd0, 24'h200FFF},
      {2'd1, 1'b0, 2'd0, 16'h1000, 2'd1, 24'h000000},
      {2'd2, 1'b1, 2'd0, 16'h0040, 2'd0, 24'hFFF040},
      {2'd2, 1'b0, 2'd0, 16'h1FFF, 2'd0, 24'h000FFF},
      {2'd3, 1'b0, 2'd0, 16'h0005, 2'd0, 24'h200005},
      {2'd0, 1'b0, 2'd2, 16'h0010, 2'd2, 24'h000000},
      {2'd1, 1'b0, 2'd1, 16'h0020, 2'd2, 24'h000000},
      {2'd1, 1'b1, 2'd1, 16'h0020, 2'd2, 24'h000000},
      {2'd1, 1'b0, 2'd3, 16'h1800, 2'd0, 24'h000800},
      {2'd1, 1'b0, 2'd0, 16'h1800, 2'd1, 24'h000000},
      {2'd2, 1'b0, 2'd0, 16'h3000, 2'd1, 24'h000000},
      {2'd1, 1'b1, 2'd1, 16'h0900, 2'd1, 24'h000000},
      {2'd0, 1'b0, 2'd1, 16'h0004, 2'd0, 24'h100004}
   };

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic load(input logic [1:0] idx, input logic [23:0] b, input logic [16:0] s,
                       input logic [2:0] r);
      ld_en = 1'b1; ld_idx = idx; ld_base = b; ld_size = s; ld_rights = r;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic xlate(input logic [1:0] t, input logic w, input logic [1:0] o,
                        input logic [15:0] off);
      xl_valid = 1'b1; xl_type = t; xl_write = w; xl_override = o; xl_offset = off;
      @(negedge clk);
      xl_valid = 1'b0;
   endtask

   task automatic expect_res(input string tag, input logic [1:0] k, input logic [23:0] pa);
      chk(res_valid == 1'b1, tag, res_valid, 1);
      chk(res_kind == k, tag, res_kind, k);
      chk(res_fault == (k != 2'd0), tag, res_fault, (k != 2'd0));
      chk(res_paddr == pa, tag, res_paddr, pa);
   endtask

   task automatic expect_desc(input string tag, input logic [1:0] idx, input logic [23:0] b,
                              input logic [16:0] s, input logic [2:0] r);
      rd_idx = idx;
      #1;
      chk(rd_base == b, tag, rd_base, b);
      chk(rd_size == s, tag, rd_size, s);
      chk(rd_rights == r, tag, rd_rights, r);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; xl_valid = 1'b0; xl_type = 2'd0; xl_write = 1'b0; xl_override = 2'd0;
      xl_offset = '0; ld_en = 1'b0; ld_idx = 2'd0; ld_base = '0; ld_size = '0;
      ld_rights = '0; rd_idx = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: cleared state
      chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
      expect_desc("R1 code clear", 2'd1, 24'h0, 17'h0, 3'b000);
      expect_desc("R1 data clear", 2'd2, 24'h0, 17'h0, 3'b000);
      expect_desc("R1 stack clear", 2'd3, 24'h0, 17'h0, 3'b000);
      xlate(2'd0, 1'b0, 2'd0, 16'h0000);
      expect_res("R1 zero length", 2'd1, 24'h0);

      // R10: idle cycle
      @(negedge clk);
      chk(res_valid == 1'b0 && res_fault == 1'b0 && res_paddr == '0, "R10 idle",
          {res_valid, res_fault, res_paddr}, 0);

      // R7 loads, R9 readback
      load(2'd1, 24'h100000, 17'h00800, 3'b001);
      load(2'd2, 24'h200000, 17'h01000, 3'b110);
      load(2'd3, 24'hFFF000, 17'h02000, 3'b110);
      expect_desc("R9 code", 2'd1, 24'h100000, 17'h00800, 3'b001);
      expect_desc("R9 data", 2'd2, 24'h200000, 17'h01000, 3'b110);
      expect_desc("R9 stack", 2'd3, 24'hFFF000, 17'h02000, 3'b110);
      expect_desc("R9 null index", 2'd0, 24'h0, 17'h0, 3'b000);

      // R7: null index strobe ignored
      load(2'd0, 24'hABCDEF, 17'h1FFFF, 3'b111);
      expect_desc("R7 null code", 2'd1, 24'h100000, 17'h00800, 3'b001);
      expect_desc("R7 null data", 2'd2, 24'h200000, 17'h01000, 3'b110);
      expect_desc("R7 null stack", 2'd3, 24'hFFF000, 17'h02000, 3'b110);

      // vector table: R2..R6
      for (int i = 0; i < NV; i++) begin
         logic [46:0] v;
         string tag;
         v = VEC[i];
         if (v[25:24] == 2'd1)      tag = $sformatf("R4 vec%0d", i);
         else if (v[25:24] == 2'd2) tag = $sformatf("R6 vec%0d", i);
         else if (v[43:42] != 2'd0) tag = $sformatf("R3 vec%0d", i);
         else if (v[46:45] != 2'd0) tag = $sformatf("R2 vec%0d", i);
         else                       tag = $sformatf("R5 vec%0d", i);
         xlate(v[46:45], v[44], v[43:42], v[41:26]);
         expect_res(tag, v[25:24], v[23:0]);
      end

      // R6: write-only data segment
      load(2'd2, 24'h200000, 17'h01000, 3'b010);
      xlate(2'd1, 1'b0, 2'd0, 16'h0010);
      expect_res("R6 read of write-only", 2'd2, 24'h0);
      xlate(2'd1, 1'b1, 2'd0, 16'h0010);
      expect_res("R6 write to write-only", 2'd0, 24'h200010);

      // R8: same-cycle reload of code uses old contents
      rd_idx = 2'd1;
      ld_en = 1'b1; ld_idx = 2'd1; ld_base = 24'h300000; ld_size = 17'h00800; ld_rights = 3'b001;
      xl_valid = 1'b1; xl_type = 2'd0; xl_write = 1'b0; xl_override = 2'd0; xl_offset = 16'h0010;
      @(negedge clk);
      ld_en = 1'b0; xl_valid = 1'b0;
      expect_res("R8 old base", 2'd0, 24'h100010);
      xlate(2'd0, 1'b0, 2'd0, 16'h0010);
      expect_res("R8 new base", 2'd0, 24'h300010);

      // R10: strobe drops after request ends
      @(negedge clk);
      chk(res_valid == 1'b0 && res_paddr == '0, "R10 drop", {res_valid, res_paddr}, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule